// File: doc/BRIEF.md
# Vectored Sixteen-Source Interrupt Controller

This block gathers sixteen interrupt sources into one processor request line and presents software with four 32-bit registers on a simple word-addressed bus. Even-numbered sources are external pins. Each of them can sense either an active-low level or a falling edge. Odd-numbered sources are internal requests that are always active-high levels. A pending register shows which sources are requesting. A mask register enables sources one by one. A sense register selects edge or level for the external pins. A read-only vector register reports the winning source.

Every register maps source n to bit 31 - n, so source 0 sits in the most significant bit. Among the sources that are both pending and enabled, the lowest-numbered one wins. Its number appears in the top six bits of the vector register, and the processor request is raised for it. An interrupt service routine reads the vector and shifts it right by 26 to get the source number. It clears an edge-latched request by writing a one to that source's pending bit.

Top module: `vintc_top`

## Requirements
- R1: After reset, the pending, mask and sense registers read zero, the vector register reads code 15 (32'h3C00_0000), and the processor request is low.
- R2: Source n occupies bit 31 - n of the pending, mask and sense registers. The word addresses are 0 for pending, 1 for mask, 2 for sense and 3 for vector. Bits 15:0 of every register read zero, and writes to them are ignored.
- R3: A mask bit of 1 enables its source and a 0 blocks it. A blocked source never raises the request or appears in the vector.
- R4: Writing 1 to a pending bit clears an edge-latched request. Writing 0 leaves the bit unchanged.
- R5: Only even-numbered sources have a writable sense bit. Odd-source sense bits always read zero, whatever is written.
- R6: With its sense bit set, a falling edge on an external pin sets the pending bit after two synchronizing stages. The bit stays set after the pin returns high, until it is cleared.
- R7: With sense cleared, a pending bit follows its synchronized input: active-low for even sources and active-high for odd ones. A write-one-to-clear has no lasting effect while the input stays asserted.
- R8: Fixed priority applies, and the lowest-numbered source that is pending and enabled is reported.
- R9: The vector register holds the code in bits 31:26, and bits 25:0 are zero. Code 15 with the request low means nothing is pending and enabled. Source 15 also reports code 15, but with the request high.
- R10: The request and the vector are registered. A mask write taken at one clock edge changes the request at the next edge. A read strobe returns its data on the read-data port after the following clock edge.
- R11: If an edge event and a write-one-to-clear for the same source arrive in the same cycle, the event wins and the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe, taken at the rising edge |
| bus_ren | input | 1 | Read strobe, data appears after the next edge |
| bus_addr | input | 2 | Word address: 0 pending, 1 mask, 2 sense, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 16 | Source inputs, bit n is source n |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
A newly detected falling edge and a software acknowledge can hit the same pending bit in one cycle. This is the race that decides whether an interrupt is lost. The bench first latches one edge on source 2 and returns the pin high. It then starts a second falling edge and times the write-one-to-clear so that it lands at the exact edge where the synchronized event reaches the pending logic. The pending register is read back afterwards, and the block passes only if the bit is still set.

// File: rtl/vintc_pkg.sv
package vintc_pkg;

  localparam int REG_W    = 32;
  localparam int CODE_W   = 6;
  localparam int CODE_LSB = REG_W - CODE_W;
  localparam int WADDR_W  = 2;
  localparam logic [CODE_W-1:0] CODE_NONE = 6'd15;

  typedef enum logic [WADDR_W-1:0] {
    RA_PEND  = 2'd0,
    RA_MASK  = 2'd1,
    RA_SENSE = 2'd2,
    RA_VEC   = 2'd3
  } reg_addr_e;

  // every implemented source, MSB-first word layout
  function automatic logic [REG_W-1:0] src_word_mask(int nsrc);
    logic [REG_W-1:0] r;
    r = '0;
    for (int n = 0; n < REG_W; n++)
      if (n < nsrc) r[REG_W-1-n] = 1'b1;
    return r;
  endfunction

  // even (external pin) sources, MSB-first word layout
  function automatic logic [REG_W-1:0] ext_word_mask(int nsrc);
    logic [REG_W-1:0] r;
    r = '0;
    for (int n = 0; n < REG_W; n++)
      if (n < nsrc && (n % 2) == 0) r[REG_W-1-n] = 1'b1;
    return r;
  endfunction

  // even sources, source-indexed (bit n = source n)
  function automatic logic [REG_W-1:0] ext_lsb_mask(int nsrc);
    logic [REG_W-1:0] r;
    r = '0;
    for (int n = 0; n < REG_W; n++)
      if (n < nsrc && (n % 2) == 0) r[n] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/vintc_sync.sv
module vintc_sync
  import vintc_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pin_i,
  output logic [NUM_SRC-1:0] act_o,
  output logic [NUM_SRC-1:0] fall_o
);

  localparam logic [REG_W-1:0]   EXT_L = ext_lsb_mask(NUM_SRC);
  localparam logic [NUM_SRC-1:0] EXT   = EXT_L[NUM_SRC-1:0];

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] stg_q;
  logic [NUM_SRC-1:0]                  prev_q;
  logic [NUM_SRC-1:0]                  sync_w;

  // reset to the idle level so no false edge follows reset
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= {SYNC_STAGES{EXT}};
      prev_q <= EXT;
    end else begin
      stg_q[0] <= pin_i;
      for (int g = 1; g < SYNC_STAGES; g++)
        stg_q[g] <= stg_q[g-1];
      prev_q <= sync_w;
    end
  end

  assign sync_w = stg_q[SYNC_STAGES-1];
  assign act_o  = sync_w ^ EXT;
  assign fall_o = prev_q & ~sync_w & EXT;

endmodule

// File: rtl/vintc_pend.sv
module vintc_pend
  import vintc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] act_i,
  input  logic [NUM_SRC-1:0] fall_i,
  input  logic [REG_W-1:0]   sense_i,
  input  logic [REG_W-1:0]   clr_i,
  output logic [REG_W-1:0]   pend_o
);

  localparam logic [REG_W-1:0] EXT_W = ext_word_mask(NUM_SRC);

  logic unused_bits;
  assign unused_bits = ^(sense_i & ~EXT_W) ^ ^(clr_i & ~EXT_W) ^ ^(fall_i & ~EXT_W[REG_W-1 -: NUM_SRC]);

  for (genvar n = 0; n < REG_W; n++) begin : g_bit
    localparam int B = REG_W - 1 - n;
    if (n < NUM_SRC && (n % 2) == 0) begin : g_ext
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else if (sense_i[B])
          bit_q <= fall_i[n] | (bit_q & ~clr_i[B]);   // new event beats clear
        else
          bit_q <= act_i[n];
      end
      assign pend_o[B] = bit_q;
    end else if (n < NUM_SRC) begin : g_int
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= act_i[n];
      end
      assign pend_o[B] = bit_q;
    end else begin : g_none
      assign pend_o[B] = 1'b0;
    end
  end

endmodule

// File: rtl/vintc_prio.sv
module vintc_prio
  import vintc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  pm_i,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);

  localparam logic [REG_W-1:0] SRC_W = src_word_mask(NUM_SRC);

  logic              hit_w;
  logic [CODE_W-1:0] code_w;
  logic              unused_bits;

  assign unused_bits = ^(pm_i & ~SRC_W);

  // scan from highest number down so the lowest number is kept last
  always_comb begin
    hit_w  = 1'b0;
    code_w = CODE_NONE;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (pm_i[REG_W-1-n]) begin
        hit_w  = 1'b1;
        code_w = CODE_W'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= CODE_NONE;
      irq_o  <= 1'b0;
    end else begin
      code_o <= code_w;
      irq_o  <= hit_w;
    end
  end

endmodule

// File: rtl/vintc_regs.sv
module vintc_regs
  import vintc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wen_i,
  input  logic               ren_i,
  input  logic [WADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [REG_W-1:0]   pend_i,
  input  logic [REG_W-1:0]   vec_i,
  output logic [REG_W-1:0]   mask_o,
  output logic [REG_W-1:0]   sense_o,
  output logic [REG_W-1:0]   clr_o,
  output logic [REG_W-1:0]   rdata_o
);

  localparam logic [REG_W-1:0] SRC_W = src_word_mask(NUM_SRC);
  localparam logic [REG_W-1:0] EXT_W = ext_word_mask(NUM_SRC);

  reg_addr_e        sel_w;
  logic [REG_W-1:0] rmux_w;

  assign sel_w = reg_addr_e'(addr_i);
  assign clr_o = (wen_i && sel_w == RA_PEND) ? (wdata_i & SRC_W) : '0;

  always_comb begin
    unique case (sel_w)
      RA_PEND:  rmux_w = pend_i;
      RA_MASK:  rmux_w = mask_o;
      RA_SENSE: rmux_w = sense_o;
      default:  rmux_w = vec_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o  <= '0;
      sense_o <= '0;
      rdata_o <= '0;
    end else begin
      if (wen_i && sel_w == RA_MASK)  mask_o  <= wdata_i & SRC_W;
      if (wen_i && sel_w == RA_SENSE) sense_o <= wdata_i & EXT_W;
      if (ren_i)                      rdata_o <= rmux_w;
    end
  end

endmodule

// File: rtl/vintc_top.sv
module vintc_top
  import vintc_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wen,
  input  logic               bus_ren,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] src_act;
  logic [NUM_SRC-1:0] src_fall;
  logic [REG_W-1:0]   pend_q;
  logic [REG_W-1:0]   mask_q;
  logic [REG_W-1:0]   sense_q;
  logic [REG_W-1:0]   clr_w;
  logic [REG_W-1:0]   pm_w;
  logic [CODE_W-1:0]  vec_code_q;
  logic [REG_W-1:0]   vec_word;

  assign pm_w     = pend_q & mask_q;
  assign vec_word = {vec_code_q, {CODE_LSB{1'b0}}};

  vintc_sync #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (src_in),
    .act_o  (src_act),
    .fall_o (src_fall)
  );

  vintc_pend #(.NUM_SRC(NUM_SRC)) pend_i (
    .clk     (clk),
    .rst     (rst),
    .act_i   (src_act),
    .fall_i  (src_fall),
    .sense_i (sense_q),
    .clr_i   (clr_w),
    .pend_o  (pend_q)
  );

  vintc_prio #(.NUM_SRC(NUM_SRC)) prio_i (
    .clk    (clk),
    .rst    (rst),
    .pm_i   (pm_w),
    .code_o (vec_code_q),
    .irq_o  (irq_o)
  );

  vintc_regs #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wen_i   (bus_wen),
    .ren_i   (bus_ren),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .pend_i  (pend_q),
    .vec_i   (vec_word),
    .mask_o  (mask_q),
    .sense_o (sense_q),
    .clr_o   (clr_w),
    .rdata_o (bus_rdata)
  );

endmodule

// File: rtl/vintc_chk.sv
module vintc_chk
  import vintc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wen,
  input logic [WADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]   bus_wdata,
  input logic               irq_o,
  input logic [CODE_W-1:0]  vec_code,
  input logic [REG_W-1:0]   pend,
  input logic [REG_W-1:0]   mask,
  input logic [REG_W-1:0]   sense,
  input logic [NUM_SRC-1:0] act
);

  localparam logic [REG_W-1:0] SRC_W = src_word_mask(NUM_SRC);
  localparam logic [REG_W-1:0] EXT_W = ext_word_mask(NUM_SRC);

  logic [REG_W-1:0] clr_seen;
  logic [REG_W-1:0] act_word;
  logic [REG_W-1:0] pm_prev;
  logic             prio_ok;

  assign clr_seen = (bus_wen && bus_addr == WADDR_W'(RA_PEND)) ? bus_wdata : '0;

  always_comb begin
    act_word = '0;
    for (int n = 0; n < NUM_SRC; n++) act_word[REG_W-1-n] = act[n];
  end

  always_ff @(posedge clk) begin
    if (rst) pm_prev <= '0;
    else     pm_prev <= pend & mask;
  end

  always_comb begin
    prio_ok = 1'b0;
    if (int'(vec_code) < NUM_SRC) begin
      prio_ok = pm_prev[REG_W-1-int'(vec_code)];
      for (int n = 0; n < NUM_SRC; n++)
        if (n < int'(vec_code) && pm_prev[REG_W-1-n]) prio_ok = 1'b0;
    end
  end

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) == '0) |-> !irq_o);

  // R9
  empty_code_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (vec_code == CODE_NONE));

  // R5
  sense_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (sense & ~EXT_W) == '0);

  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & $past(pend & sense & ~clr_seen)) == $past(pend & sense & ~clr_seen));

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) == 1'b0) |-> (((pend ^ $past(act_word)) & ~$past(sense) & SRC_W) == '0));

  // R8
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> prio_ok);

endmodule

bind vintc_top vintc_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wen   (bus_wen),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .vec_code  (vec_code_q),
  .pend      (pend_q),
  .mask      (mask_q),
  .sense     (sense_q),
  .act       (src_act)
);

// File: tb/vintc_top_tb_top.sv
module vintc_top_tb_top;

  localparam int NS = 16;
  localparam logic [15:0] IDLE = 16'h5555;   // even pins high, odd low
  localparam int WD_LIMIT = 20000;

  typedef struct packed {
    logic [15:0] act;
    logic [31:0] mask;
    logic [5:0]  code;
    logic        irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 32'hFFFF_0000, 6'd15, 1'b0},
    '{16'h0001, 32'hFFFF_0000, 6'd0,  1'b1},
    '{16'h0208, 32'hFFFF_0000, 6'd3,  1'b1},
    '{16'h0208, 32'h0040_0000, 6'd9,  1'b1},
    '{16'h0020, 32'h0000_0000, 6'd15, 1'b0},
    '{16'h8000, 32'hFFFF_0000, 6'd15, 1'b1},
    '{16'hC000, 32'h0001_0000, 6'd15, 1'b1},
    '{16'hFFFF, 32'h0000_FFFF, 6'd15, 1'b0},
    '{16'h4010, 32'hFFFF_0000, 6'd4,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic        bus_ren = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] src_in = IDLE;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vintc_top dut_i (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, actual, expected);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] to_word(input logic [15:0] a);
    logic [31:0] w;
    w = '0;
    for (int n = 0; n < NS; n++) w[31-n] = a[n];
    return w;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    bus_read(2'd0, rd); check("R1 pending", rd, 32'h0);
    bus_read(2'd1, rd); check("R1 mask", rd, 32'h0);
    bus_read(2'd2, rd); check("R1 sense", rd, 32'h0);
    bus_read(2'd3, rd); check("R1 vector", rd, 32'h3C00_0000);
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    // table walk, level sensing (R2 R3 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      bus_write(2'd1, TBL[v].mask);
      src_in = IDLE ^ TBL[v].act;
      idle(5);
      bus_read(2'd0, rd); check("R7 pending level", rd, to_word(TBL[v].act));
      bus_read(2'd1, rd); check("R2 mask low bits", rd, TBL[v].mask & 32'hFFFF_0000);
      bus_read(2'd3, rd); check("R8 R9 vector", rd, {TBL[v].code, 26'h0});
      check("R3 irq", {31'h0, irq_o}, {31'h0, TBL[v].irq});
    end
    src_in = IDLE;
    bus_write(2'd1, 32'h0);
    idle(4);

    // R5 odd sense bits not writable
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, rd); check("R5 sense even only", rd, 32'hAAAA_0000);

    // R6 edge latch on source 2
    bus_write(2'd2, 32'h2000_0000);
    bus_write(2'd1, 32'h2000_0000);
    src_in = IDLE & ~16'h0004;
    idle(1);
    src_in = IDLE;
    idle(6);
    bus_read(2'd0, rd); check("R6 sticky pending", rd, 32'h2000_0000);
    bus_read(2'd3, rd); check("R6 vector", rd, {6'd2, 26'h0});
    check("R6 irq", {31'h0, irq_o}, 32'h1);

    // R4 write zero no effect, write one clears
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, rd); check("R4 write zero", rd, 32'h2000_0000);
    bus_write(2'd0, 32'h2000_0000);
    idle(1);
    bus_read(2'd0, rd); check("R4 clear", rd, 32'h0);
    check("R4 irq low", {31'h0, irq_o}, 32'h0);

    // R11 edge event and clear in the same cycle
    src_in = IDLE & ~16'h0004; idle(1); src_in = IDLE; idle(6);
    bus_read(2'd0, rd); check("R11 setup", rd, 32'h2000_0000);
    @(negedge clk);
    src_in = IDLE & ~16'h0004;
    @(negedge clk);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h2000_0000;
    @(negedge clk);
    bus_wen = 1'b0;
    bus_read(2'd0, rd); check("R11 event wins", rd, 32'h2000_0000);
    src_in = IDLE;
    idle(4);
    bus_write(2'd0, 32'h2000_0000);
    bus_read(2'd0, rd); check("R4 clear after race", rd, 32'h0);

    // R7 clear has no lasting effect on an asserted level (source 1)
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'h0);
    src_in = IDLE | 16'h0002;
    idle(5);
    bus_write(2'd0, 32'h4000_0000);
    idle(2);
    bus_read(2'd0, rd); check("R7 level w1c", rd, 32'h4000_0000);

    // R10 mask write to request latency (source 0, active-low)
    src_in = IDLE & ~16'h0001;
    idle(5);
    check("R10 irq before", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h8000_0000;
    @(negedge clk);
    bus_wen = 1'b0;
    check("R10 irq one edge", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R10 irq two edges", {31'h0, irq_o}, 32'h1);
    bus_read(2'd3, rd); check("R10 vector read", rd, 32'h0);

    finish_run();
  end

endmodule